// File: doc/BRIEF.md
# Gate Driver Safe-State Supervisor

This block sits on the isolated side of a gate driver. On every clock it decides whether the power-stage output may follow the commanded drive level, or whether it must be parked in the safe state. The safe state has the sink switch on, the source switch off and the Miller clamp on. The block takes digitized codes for three quantities: the gate supply, the junction temperature and the monitored gate voltage. It also takes a heartbeat pulse from the control side, a logic-supply-good flag and the drive command. All thresholds are parameters.

Four fault sources are combined with OR:

- supply lockout, with hysteresis;
- thermal shutdown, with hysteresis;
- link loss, detected by a heartbeat watchdog;
- absence of the logic supply.

Each fault is held in its own registered flag, and the flags are reported on a status port. A four-state sequencer drives the three switch enables:

- `ST_SAFE`: the safe state.
- `ST_OFF`: normal off. The sink is on, and the clamp follows the gate-voltage code.
- `ST_GAP`: a one-cycle dead time with every switch open.
- `ST_ON`: the source is on.

The sequencer takes these transitions:

- Any fault moves every state to `ST_SAFE`.
- From `ST_SAFE` with no fault, the next state is `ST_GAP` when the command is on, and `ST_OFF` otherwise.
- From `ST_OFF`, a command on leads to `ST_GAP`.
- From `ST_GAP`, a command on leads to `ST_ON`, and a command off leads back to `ST_OFF`.
- From `ST_ON`, a command off leads to `ST_OFF`.

Top module: `gdrv_safe_supervisor`

## Requirements
- R1: While reset is asserted, and on leaving it, the outputs are src_en=0, snk_en=1, clamp_en=1 and fault_flags=4'b1111. Every fault counts as active until it has been evaluated.
- R2: In the cycle after any fault flag is set, the outputs are src_en=0, snk_en=1 and clamp_en=1, regardless of cmd_on and gate_code.
- R3: Flag bit 0 (supply lockout) sets when vh_code < VH_OFF_TH (168). It clears only when vh_code >= VH_ON_TH (182). Codes in between keep its previous value.
- R4: Flag bit 1 (thermal) sets when temp_code >= TSD_TH (170). It clears only when temp_code < TSD_TH - TSD_HYS (150). Codes in between keep its previous value.
- R5: Flag bit 2 (link lost) sets after LINK_TIMEOUT (16) consecutive clock edges with no hb_pulse following the last pulse; pulses spaced 16 edges apart keep the link. Once the link is lost, the flag clears on the LINK_RESTORE-th (3rd) heartbeat, provided no timeout occurs between the heartbeats.
- R6: Flag bit 3 (logic supply) is the inverse of lv_ok, registered one cycle.
- R7: When the last fault clears, the output follows the present cmd_on without needing a new command edge. With cmd_on held high, src_en rises two cycles after the flags clear.
- R8: src_en and snk_en are never high together. Turning on passes through one cycle with both low, so snk_en falls one cycle before src_en rises. Turning off switches directly from `ST_ON` to `ST_OFF`.
- R9: In `ST_OFF`, clamp_en = (gate_code < CLAMP_TH (40)), combinationally. In `ST_GAP` and `ST_ON`, clamp_en is 0.
- R10: Each fault flag reflects its inputs one clock edge after they are sampled, and the outputs reach the safe state on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vh_code | input | VH_W | Digitized gate-supply voltage |
| temp_code | input | TEMP_W | Digitized junction temperature |
| hb_pulse | input | 1 | One-cycle heartbeat from the logic side |
| lv_ok | input | 1 | Logic-side supply good |
| cmd_on | input | 1 | Commanded drive level |
| gate_code | input | GATE_W | Digitized monitored gate voltage |
| src_en | output | 1 | Source switch enable |
| snk_en | output | 1 | Sink switch enable |
| clamp_en | output | 1 | Miller clamp enable |
| fault_flags | output | 4 | {logic supply, link, thermal, supply lockout} |

## Verification
A flag register that holds a stale value shows up on fault_flags on the very next edge. It also turns into a wrong safe or drive encoding one edge later. A sequencer stuck in the wrong state shows up immediately on the three enables: both switches on, a missing dead-time cycle, or a clamp that disagrees with the gate code. The bench therefore compares every port on every cycle against its own cycle-accurate expectation. It also drives the hysteresis band edges and heartbeat spacings of exactly and one more than the timeout.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
    typedef enum logic [1:0] {
        ST_SAFE = 2'd0,
        ST_OFF  = 2'd1,
        ST_GAP  = 2'd2,
        ST_ON   = 2'd3
    } drv_state_e;

    typedef struct packed {
        logic lvsup;
        logic link;
        logic therm;
        logic uvlo;
    } fault_t;
endpackage

// File: rtl/gdrv_hyst_mon.sv
module gdrv_hyst_mon #(
    parameter int             W         = 8,
    parameter logic [W-1:0]   TRIP_TH   = '0,
    parameter logic [W-1:0]   REL_TH    = '0,
    parameter bit             TRIP_HIGH = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] value,
    output logic         flag_o
);
    logic trip;
    logic rel;

    generate
        if (TRIP_HIGH) begin : g_high
            assign trip = (value >= TRIP_TH);
            assign rel  = (value < REL_TH);
        end else begin : g_low
            assign trip = (value < TRIP_TH);
            assign rel  = (value >= REL_TH);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b1;
        else if (flag_o) flag_o <= ~rel;
        else             flag_o <= trip;
    end

    p_trip_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> flag_o);
    p_hold_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !rel) |=> flag_o);
    p_release_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && rel && !trip) |=> !flag_o);
endmodule

// File: rtl/gdrv_link_wdog.sv
module gdrv_link_wdog #(
    parameter int TIMEOUT = 16,
    parameter int RESTORE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_pulse,
    output logic link_lost_o
);
    localparam int GW = $clog2(TIMEOUT + 1);
    localparam int CW = $clog2(RESTORE + 1);
    localparam logic [GW-1:0] GAP_LIM = GW'(TIMEOUT - 1);
    localparam logic [CW-1:0] HB_LIM  = CW'(RESTORE - 1);

    logic [GW-1:0] gap_q;
    logic [CW-1:0] hb_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q       <= '0;
            hb_cnt_q    <= '0;
            link_lost_o <= 1'b1;
        end else if (hb_pulse) begin
            gap_q <= '0;
            if (link_lost_o) begin
                if (hb_cnt_q == HB_LIM) begin
                    link_lost_o <= 1'b0;
                    hb_cnt_q    <= '0;
                end else begin
                    hb_cnt_q <= hb_cnt_q + 1'b1;
                end
            end
        end else if (gap_q == GAP_LIM) begin
            gap_q       <= '0;
            hb_cnt_q    <= '0;
            link_lost_o <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hb_pulse && gap_q == GAP_LIM) |=> link_lost_o);
    p_hb_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_lost_o && hb_pulse) |=> !link_lost_o);
endmodule

// File: rtl/gdrv_safe_supervisor.sv
module gdrv_safe_supervisor
    import gdrv_pkg::*;
#(
    parameter int                VH_W         = 8,
    parameter int                TEMP_W       = 8,
    parameter int                GATE_W       = 8,
    parameter logic [VH_W-1:0]   VH_ON_TH     = 8'd182,
    parameter logic [VH_W-1:0]   VH_OFF_TH    = 8'd168,
    parameter logic [TEMP_W-1:0] TSD_TH       = 8'd170,
    parameter logic [TEMP_W-1:0] TSD_HYS      = 8'd20,
    parameter logic [GATE_W-1:0] CLAMP_TH     = 8'd40,
    parameter int                LINK_TIMEOUT = 16,
    parameter int                LINK_RESTORE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VH_W-1:0]   vh_code,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              hb_pulse,
    input  logic              lv_ok,
    input  logic              cmd_on,
    input  logic [GATE_W-1:0] gate_code,
    output logic              src_en,
    output logic              snk_en,
    output logic              clamp_en,
    output logic [3:0]        fault_flags
);
    localparam logic [TEMP_W-1:0] TSD_REL_TH = TSD_TH - TSD_HYS;

    fault_t     flt;
    logic       any_fault;
    drv_state_e state_q;
    drv_state_e state_d;

    gdrv_hyst_mon #(
        .W(VH_W), .TRIP_TH(VH_OFF_TH), .REL_TH(VH_ON_TH), .TRIP_HIGH(1'b0)
    ) u_uvlo (
        .clk(clk), .rst_n(rst_n), .value(vh_code), .flag_o(flt.uvlo)
    );

    gdrv_hyst_mon #(
        .W(TEMP_W), .TRIP_TH(TSD_TH), .REL_TH(TSD_REL_TH), .TRIP_HIGH(1'b1)
    ) u_therm (
        .clk(clk), .rst_n(rst_n), .value(temp_code), .flag_o(flt.therm)
    );

    gdrv_link_wdog #(
        .TIMEOUT(LINK_TIMEOUT), .RESTORE(LINK_RESTORE)
    ) u_wdog (
        .clk(clk), .rst_n(rst_n), .hb_pulse(hb_pulse), .link_lost_o(flt.link)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) flt.lvsup <= 1'b1;
        else        flt.lvsup <= ~lv_ok;
    end

    assign any_fault   = |flt;
    assign fault_flags = flt;

    always_comb begin
        state_d = state_q;
        if (any_fault) begin
            state_d = ST_SAFE;
        end else begin
            unique case (state_q)
                ST_SAFE: state_d = cmd_on ? ST_GAP : ST_OFF;
                ST_OFF:  state_d = cmd_on ? ST_GAP : ST_OFF;
                ST_GAP:  state_d = cmd_on ? ST_ON  : ST_OFF;
                ST_ON:   state_d = cmd_on ? ST_ON  : ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SAFE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_SAFE: begin src_en = 1'b0; snk_en = 1'b1; clamp_en = 1'b1; end
            ST_OFF:  begin src_en = 1'b0; snk_en = 1'b1; clamp_en = (gate_code < CLAMP_TH); end
            ST_GAP:  begin src_en = 1'b0; snk_en = 1'b0; clamp_en = 1'b0; end
            ST_ON:   begin src_en = 1'b1; snk_en = 1'b0; clamp_en = 1'b0; end
        endcase
    end

    p_safe_enc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_fault |=> (snk_en && !src_en && clamp_en));
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_en && snk_en));
    p_gap_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_en) |-> !$past(snk_en));
    p_lv_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lv_ok |=> fault_flags[3]);
    p_clamp_sink_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_en |-> snk_en);
endmodule

// File: tb/sim_gdrv_safe_supervisor.sv
module sim_gdrv_safe_supervisor;
    localparam int ON_TH = 182, OFF_TH = 168, TSD = 170, HYS = 20, CLT = 40;
    localparam int N = 16, K = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] vh_code = 8'd200, temp_code = 8'd100, gate_code = 8'd0;
    logic hb_pulse = 1'b0, lv_ok = 1'b1, cmd_on = 1'b0;
    logic src_en, snk_en, clamp_en;
    logic [3:0] fault_flags;

    int errors = 0, checks = 0;
    int hb_per = 4, hb_tmr = 0;
    // expected-state variables: 0 safe, 1 off, 2 gap, 3 on
    int m_st = 0, m_gap = 0, m_hbc = 0;
    bit m_uv = 1, m_hot = 1, m_lnk = 1, m_lvf = 1;

    always #10 clk = ~clk;

    gdrv_safe_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .vh_code(vh_code), .temp_code(temp_code),
        .hb_pulse(hb_pulse), .lv_ok(lv_ok), .cmd_on(cmd_on), .gate_code(gate_code),
        .src_en(src_en), .snk_en(snk_en), .clamp_en(clamp_en), .fault_flags(fault_flags)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_fault();
        return m_uv | m_hot | m_lnk | m_lvf;
    endfunction

    task automatic model_edge();
        if (exp_fault()) m_st = 0;
        else case (m_st)
            0, 1: m_st = cmd_on ? 2 : 1;
            2:    m_st = cmd_on ? 3 : 1;
            default: m_st = cmd_on ? 3 : 1;
        endcase
        m_uv  = m_uv  ? !(vh_code >= ON_TH) : (vh_code < OFF_TH);
        m_hot = m_hot ? !(temp_code < TSD - HYS) : (temp_code >= TSD);
        m_lvf = !lv_ok;
        if (hb_pulse) begin
            m_gap = 0;
            if (m_lnk) begin
                if (m_hbc == K - 1) begin m_lnk = 0; m_hbc = 0; end
                else m_hbc++;
            end
        end else if (m_gap == N - 1) begin
            m_lnk = 1; m_hbc = 0; m_gap = 0;
        end else m_gap++;
    endtask

    task automatic compare_all();
        int e_src, e_snk, e_clp;
        string t_out;
        t_out = (m_st == 0) ? "R2" : "R8";
        e_src = (m_st == 3);
        e_snk = (m_st <= 1);
        e_clp = (m_st == 0) ? 1 : (m_st == 1) ? int'(gate_code < CLT) : 0;
        chk({t_out, " src_en"}, int'(src_en), e_src);
        chk({t_out, " snk_en"}, int'(snk_en), e_snk);
        chk((m_st == 0) ? "R2 clamp_en" : "R9 clamp_en", int'(clamp_en), e_clp);
        chk("R3 uvlo flag",  int'(fault_flags[0]), int'(m_uv));
        chk("R4 therm flag", int'(fault_flags[1]), int'(m_hot));
        chk("R5 link flag",  int'(fault_flags[2]), int'(m_lnk));
        chk("R6 lv flag",    int'(fault_flags[3]), int'(m_lvf));
    endtask

    // called at a negedge after inputs are set; returns at the next negedge
    task automatic cycle();
        hb_pulse = (hb_tmr == 0);
        hb_tmr = (hb_tmr + 1) % hb_per;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 src_en", int'(src_en), 0);
        chk("R1 snk_en", int'(snk_en), 1);
        chk("R1 clamp_en", int'(clamp_en), 1);
        chk("R1 flags", int'(fault_flags), 15);
        rst_n = 1'b1;
        cmd_on = 1'b1;
        run(20);
        chk("R8 drive after bring-up", int'(src_en), 1);

        // R3 lockout band with command held on, then R7/R10 resume
        vh_code = 8'd167; run(3);
        chk("R3 below off threshold", int'(fault_flags[0]), 1);
        vh_code = 8'd181; run(4);
        chk("R3 band keeps lockout", int'(snk_en), 1);
        vh_code = 8'd182; run(1);
        chk("R10 flag clears next edge", int'(fault_flags[0]), 0);
        chk("R10 still safe", int'(clamp_en), 1);
        run(1);
        chk("R8 dead time", int'(snk_en | src_en), 0);
        run(1);
        chk("R7 resumes without new edge", int'(src_en), 1);
        vh_code = 8'd168; run(3);
        chk("R3 at off threshold no trip", int'(fault_flags[0]), 0);

        // R4 thermal band
        temp_code = 8'd170; run(3);
        chk("R4 trip at threshold", int'(fault_flags[1]), 1);
        temp_code = 8'd150; run(3);
        chk("R4 hold at release edge", int'(fault_flags[1]), 1);
        temp_code = 8'd149; run(3);
        chk("R4 released", int'(fault_flags[1]), 0);

        // R9 clamp in normal off
        cmd_on = 1'b0; gate_code = 8'd39; run(2);
        chk("R9 clamp below threshold", int'(clamp_en), 1);
        gate_code = 8'd40; run(1);
        chk("R9 clamp at threshold", int'(clamp_en), 0);

        // R5 watchdog spacing
        hb_per = N; run(60);
        chk("R5 spacing N keeps link", int'(fault_flags[2]), 0);
        hb_per = N + 1; run(40);
        chk("R5 spacing N+1 loses link", int'(fault_flags[2]), 1);
        hb_per = 4; run(20);
        chk("R5 restored", int'(fault_flags[2]), 0);

        // R6 logic supply
        lv_ok = 1'b0; run(2);
        chk("R6 lv missing", int'(fault_flags[3]), 1);
        lv_ok = 1'b1; run(2);

        // constrained random mix
        for (int blk = 0; blk < 60; blk++) begin
            hb_per = 3 + int'($urandom_range(0, 15));
            for (int i = 0; i < 40; i++) begin
                vh_code   = 8'($urandom_range(160, 195));
                temp_code = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(140, 180))
                                                        : 8'($urandom_range(100, 148));
                lv_ok     = ($urandom_range(0, 31) != 0);
                cmd_on    = $urandom_range(0, 1) == 1;
                gate_code = 8'($urandom_range(20, 60));
                if ($urandom_range(0, 1) == 1) vh_code = 8'd190;
                cycle();
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule